// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock timing for an I2C master from a fast reference clock. Two registers set the timing. A mode word carries the enable, a two-bit prescale select and a filter option. A divider word holds an 8-bit value. The block drives the open-drain SCL request and gives the bit engine two pulses: one in the middle of each SCL high phase, where SDA is sampled, and one at the end of every SCL period.

A fixed formula gives the SCL timing. The prescaler divides the reference by a power of two. Each SCL phase, low or high, then lasts the divider value plus three prescaled ticks, and two more ticks when the filter is on. A slave that holds SCL low while the block has released it pauses the high-phase count. With the filter on, the SCL and SDA inputs pass through a majority stage before they reach the bit engine. While the enable is clear, the counters stay in reset and SCL is left released. A configuration change made while the block runs takes effect only at the next period boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: A write with `cfg_sel`=0 loads the mode word: bit 0 is the enable, bits 2:1 the prescale select m, bit 3 the filter enable f, and bits 7:4 are ignored. A write with `cfg_sel`=1 loads the 8-bit divider d.
- R2: The prescaled tick comes every 32 >> m reference cycles, that is 32, 16, 8 or 4 cycles.
- R3: Each SCL period starts with a low phase (`scl_drive_low`=1) followed by a high phase (`scl_drive_low`=0). Each phase lasts h = d + 3 + 2·f prescaled ticks. `bit_tick` pulses for one cycle in the first cycle of the next low phase.
- R4: `sample_stb` pulses exactly once per high phase, (h >> 1) prescaled ticks after the high phase begins.
- R5: While the enable is 0, `scl_drive_low`, `bit_tick` and `sample_stb` stay 0. Setting the enable starts a full low phase of h ticks.
- R6: The divider, select and filter values in use change only while the block is disabled or at a period boundary. A write that lands in the boundary cycle applies to the period that starts there.
- R7: In the high phase, a prescaled tick at which the synchronised SCL input is low does not advance the count. This extends the high phase for as long as a slave stretches the clock.
- R8: With f=1, `sda_line` and `scl_line` are the majority of the synchronised input and two stages that shift on each prescaled tick, so a one-cycle glitch is suppressed. With f=0 they follow the synchronised input.
- R9: After reset the block is disabled with d=0, m=0 and f=0. SCL is released, both strobes are 0, and both filtered lines read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mode word, 1 divider |
| cfg_wdata | input | 8 | Register write data |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| scl_line | output | 1 | SCL level for the bit engine |
| sda_line | output | 1 | SDA level for the bit engine |
| sample_stb | output | 1 | Mid-high-phase sampling pulse |
| bit_tick | output | 1 | End-of-period pulse |

## Verification
A register write and the end of an SCL period can fall in the same cycle. In that cycle the configuration in use is reloaded while the divider register itself is being written. The bench counts the reference cycles of the running high phase and holds a divider write across exactly the clock edge that ends it. The write is judged to land correctly if the low phase that follows already has the length set by the new divider. A second case writes in the middle of a low phase and checks that the running period keeps the old length.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;
  localparam int DIV_W    = 8;
  localparam int SEL_W    = 2;
  localparam int PRE_LOG  = 5;
  localparam int BASE_OFS = 3;
  localparam int FLT_OFS  = 2;
  localparam int PRE_W    = PRE_LOG;
  localparam int CNT_W    = DIV_W + 1;
  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_SEL_LSB = 1;
  localparam int MODE_FLT_BIT = MODE_SEL_LSB + SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             flt;
    logic [DIV_W-1:0] brg;
  } rate_cfg_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  // last value of the prescale counter for a select code
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    int sh;
    sh = PRE_LOG - int'(sel);
    return PRE_W'((1 << sh) - 1);
  endfunction

  // prescaled ticks in one SCL phase
  function automatic logic [CNT_W-1:0] half_ticks(input rate_cfg_t c);
    logic [CNT_W-1:0] extra;
    extra = c.flt ? CNT_W'(FLT_OFS) : '0;
    return CNT_W'(c.brg) + CNT_W'(BASE_OFS) + extra;
  endfunction
endpackage

// File: rtl/i2cbr_cfg_regs.sv
module i2cbr_cfg_regs
  import i2cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [DIV_W-1:0] wdata,
  output logic             en_q,
  output rate_cfg_t        cfg_nx
);
  rate_cfg_t cfg_q;
  logic      en_nx;

  always_comb begin
    en_nx  = en_q;
    cfg_nx = cfg_q;
    if (we) begin
      if (!sel) begin
        en_nx      = wdata[MODE_EN_BIT];
        cfg_nx.sel = wdata[MODE_SEL_LSB +: SEL_W];
        cfg_nx.flt = wdata[MODE_FLT_BIT];
      end else begin
        cfg_nx.brg = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      en_q  <= en_nx;
      cfg_q <= cfg_nx;
    end
  end
endmodule

// File: rtl/i2cbr_prescaler.sv
module i2cbr_prescaler
  import i2cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] last,
  output logic [PRE_W-1:0] cnt,
  output logic             tick
);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cbr_line_filter.sv
// Line 0 is SCL; its synchronised level is also brought out unfiltered.
module i2cbr_line_filter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         shift,
  input  logic         use_maj,
  output logic [N-1:0] filt,
  output logic         scl_sync
);
  logic [N-1:0] s1, s2, st0, st1;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1[g]  <= 1'b1;
        s2[g]  <= 1'b1;
        st0[g] <= 1'b1;
        st1[g] <= 1'b1;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        if (shift) begin
          st0[g] <= s2[g];
          st1[g] <= st0[g];
        end
      end
    end
    assign filt[g] = use_maj ? ((s2[g] & st0[g]) | (s2[g] & st1[g]) | (st0[g] & st1[g]))
                             : s2[g];
  end

  assign scl_sync = s2[0];
endmodule

// File: rtl/i2cbr_phase_seq.sv
module i2cbr_phase_seq
  import i2cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             scl_seen,
  input  logic [CNT_W-1:0] half,
  output logic             phase_hi,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             drive_low,
  output logic             bit_tick,
  output logic             mid_stb
);
  phase_e phase;
  logic   advance, last_cnt, mid_hit;

  assign advance   = run && tick && ((phase == PH_LOW) || scl_seen);
  assign last_cnt  = (cnt == half - 1'b1);
  assign mid_hit   = (cnt == (half >> 1) - 1'b1);
  assign boundary  = advance && (phase == PH_HIGH) && last_cnt;
  assign phase_hi  = (phase == PH_HIGH);
  assign drive_low = run && (phase == PH_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase    <= PH_LOW;
      cnt      <= '0;
      bit_tick <= 1'b0;
      mid_stb  <= 1'b0;
    end else begin
      bit_tick <= boundary;
      mid_stb  <= advance && (phase == PH_HIGH) && mid_hit;
      if (advance) begin
        if (last_cnt) begin
          cnt   <= '0;
          phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import i2cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             scl_line,
  output logic             sda_line,
  output logic             sample_stb,
  output logic             bit_tick
);
  localparam int LINES = 2;

  logic             en_q;
  rate_cfg_t        cfg_nx, act_cfg;
  logic [PRE_W-1:0] pre_cnt, pre_last_v;
  logic             pre_tick, scl_seen, boundary, phase_hi;
  logic [CNT_W-1:0] ph_cnt, half_v;
  logic [LINES-1:0] filt_v;

  i2cbr_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(en_q), .cfg_nx(cfg_nx)
  );

  // configuration in use: follows the registers while idle, reloads at period end
  always_ff @(posedge clk) begin
    if (!rst_n)                   act_cfg <= '0;
    else if (!en_q || boundary)   act_cfg <= cfg_nx;
  end

  assign pre_last_v = pre_last(act_cfg.sel);
  assign half_v     = half_ticks(act_cfg);

  i2cbr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q), .last(pre_last_v),
    .cnt(pre_cnt), .tick(pre_tick)
  );

  i2cbr_line_filter #(.N(LINES)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw({sda_in, scl_in}),
    .shift(pre_tick || !en_q), .use_maj(act_cfg.flt),
    .filt(filt_v), .scl_sync(scl_seen)
  );

  assign scl_line = filt_v[0];
  assign sda_line = filt_v[1];

  i2cbr_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(pre_tick), .scl_seen(scl_seen),
    .half(half_v), .phase_hi(phase_hi), .cnt(ph_cnt), .boundary(boundary),
    .drive_low(scl_drive_low), .bit_tick(bit_tick), .mid_stb(sample_stb)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import i2cbr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             phase_hi,
  input logic [CNT_W-1:0] ph_cnt,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_last_v,
  input logic             pre_tick,
  input logic             scl_seen,
  input logic             boundary,
  input logic             scl_drive_low,
  input logic             bit_tick,
  input logic             sample_stb,
  input logic [DIV_W-1:0] act_brg
);
  a_r5_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !scl_drive_low);

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!bit_tick && !sample_stb));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_tick, sample_stb}));

  a_r3_tick_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (!phase_hi && $past(phase_hi)));

  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last_v);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && phase_hi && pre_tick && !scl_seen) |=>
      (!en_q || (phase_hi && $stable(ph_cnt) && !bit_tick)));

  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !boundary) |=> $stable(act_brg));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .phase_hi(phase_hi), .ph_cnt(ph_cnt),
  .pre_cnt(pre_cnt), .pre_last_v(pre_last_v), .pre_tick(pre_tick),
  .scl_seen(scl_seen), .boundary(boundary), .scl_drive_low(scl_drive_low),
  .bit_tick(bit_tick), .sample_stb(sample_stb), .act_brg(act_cfg.brg)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n, cfg_we, cfg_sel, sda_in, stretch;
  logic [7:0] cfg_wdata;
  wire        scl_in;
  logic       scl_drive_low, scl_line, sda_line, sample_stb, bit_tick;
  int         nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;
  assign scl_in = ~scl_drive_low & ~stretch;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .scl_line(scl_line), .sda_line(sda_line), .sample_stb(sample_stb), .bit_tick(bit_tick)
  );

  // {select[1:0], filter, divider[7:0]}
  localparam logic [10:0] VEC [0:5] = '{
    {2'd0, 1'b0, 8'd0}, {2'd1, 1'b0, 8'd5}, {2'd2, 1'b1, 8'd2},
    {2'd3, 1'b0, 8'd0}, {2'd3, 1'b1, 8'd9}, {2'd2, 1'b0, 8'd255}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic meas_low(output int n);
    n = 0;
    while (scl_drive_low) begin n++; @(negedge clk); end
  endtask

  task automatic meas_high(output int m, output int mid, output int nmid, output int tk);
    m = 0; mid = -1; nmid = 0;
    while (!scl_drive_low) begin
      if (sample_stb) begin nmid++; if (mid < 0) mid = m; end
      m++; @(negedge clk);
    end
    tk = int'(bit_tick);
  endtask

  initial begin
    #(150000 * 5);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n, m, mid, nmid, tk, pre, half, viol, seen;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    sda_in = 1'b1; stretch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 scl_drive_low", int'(scl_drive_low), 0);
    chk("R9 strobes", int'(bit_tick) + int'(sample_stb), 0);
    chk("R9 lines", int'(scl_line) + int'(sda_line), 2);

    // R1 R2 R3 R4 over the vector table
    for (int i = 0; i < 6; i++) begin
      pre  = 32 >> VEC[i][10:9];
      half = int'(VEC[i][7:0]) + 3 + 2 * int'(VEC[i][8]);
      wr(1'b0, 8'h00);
      wr(1'b1, VEC[i][7:0]);
      wr(1'b0, {4'b1010, VEC[i][8], VEC[i][10:9], 1'b1}); // upper bits ignored (R1)
      meas_low(n);
      chk("R1/R2/R3 low phase", n, half * pre);
      meas_high(m, mid, nmid, tk);
      chk("R2/R3 high phase", m, half * pre);
      chk("R4 sample offset", mid, (half >> 1) * pre);
      chk("R4 one sample per high", nmid, 1);
      chk("R3 bit_tick at period end", tk, 1);
    end

    // R6 write mid low phase: period keeps old divider
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd4);
    wr(1'b0, 8'h07);                         // pre 4, h 7
    n = 0;
    while (scl_drive_low) begin
      if (n == 5) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'd1; end
      if (n == 6) cfg_we = 1'b0;
      n++; @(negedge clk);
    end
    chk("R6 low unaffected", n, 28);
    meas_high(m, mid, nmid, tk);
    chk("R6 high unaffected", m, 28);
    meas_low(n);
    chk("R6 new divider next period", n, 16);
    // R6 write held across the boundary edge
    m = 0;
    while (!scl_drive_low) begin
      if (m == 15) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'd6; end
      m++; @(negedge clk);
    end
    cfg_we = 1'b0;
    chk("R6 boundary high", m, 16);
    meas_low(n);
    chk("R6 boundary write applies", n, 36);

    // R7 clock stretching
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd2);
    wr(1'b0, 8'h07);                         // pre 4, h 5
    meas_low(n);
    chk("R7 low before stretch", n, 20);
    m = 0;
    while (!scl_drive_low) begin
      if (m == 0)  stretch = 1'b1;
      if (m == 10) stretch = 1'b0;
      m++; @(negedge clk);
    end
    chk("R7 stretched high in range", int'(m >= 30 && m <= 36), 1);
    chk("R7 bit_tick after stretch", int'(bit_tick), 1);

    // R5 disable and fresh restart
    wr(1'b0, 8'h06);
    viol = 0;
    repeat (40) begin
      if (scl_drive_low || bit_tick || sample_stb) viol++;
      @(negedge clk);
    end
    chk("R5 idle outputs", viol, 0);
    wr(1'b0, 8'h07);
    meas_low(n);
    chk("R5 fresh low phase", n, 20);

    // R8 filter on: glitch suppressed, steady level passes
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd0);
    wr(1'b0, 8'h0F);
    repeat (5) @(negedge clk);
    sda_in = 1'b0; @(negedge clk); sda_in = 1'b1;
    seen = 0;
    repeat (12) begin if (!sda_line) seen++; @(negedge clk); end
    chk("R8 glitch suppressed", seen, 0);
    sda_in = 1'b0; seen = 0;
    repeat (30) begin if (!sda_line) seen++; @(negedge clk); end
    chk("R8 steady low passes", int'(seen > 0), 1);
    sda_in = 1'b1;
    repeat (30) @(negedge clk);
    // R8 filter off: glitch visible
    wr(1'b0, 8'h06);
    repeat (4) @(negedge clk);
    sda_in = 1'b0; @(negedge clk); sda_in = 1'b1;
    seen = 0;
    repeat (8) begin if (!sda_line) seen++; @(negedge clk); end
    chk("R8 unfiltered glitch", seen, 1);

    summary();
  end
endmodule